// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipe that can feed a CRT-style monitor and a flat panel at the same time. A pixel counter runs across each line and a line counter runs down each frame. Comparators on both counters produce a coarse CRT horizontal sync, a pixel-exact panel horizontal sync, a vertical sync, horizontal and vertical blanking, a pixel-active flag, and the current pixel and line numbers. Every output is registered and describes the same pixel and line pair in a given cycle.

Timing comes from six 32-bit registers. Each register holds two 11-bit fields, each programmed as the wanted position or count minus one. A lock input freezes the registers against writes. The line counter does not step at the end of the line. It steps where the CRT horizontal sync would begin, so the CRT sync start must be programmed even when only a panel is attached. An interlace input makes the vertical total odd and takes the vertical blank window from the total and active values, with no border.

Top module: `raster_timing_gen`

## Requirements
- R1: A clock edge with `rst_n` low sets `pix_x`, `line_y`, `rd_data` and every sync, blank and active output to 0, and clears every stored timing field to 0.
- R2: `pix_x` counts up by one per cycle and goes to 0 in the cycle after it equals or exceeds the horizontal total. `hblank` is 1 exactly when `pix_x` is greater than the horizontal active field.
- R3: `crt_hsync` is 1 when `pix_x[10:3]` is at least `crt_start[10:3]` and below `crt_end[10:3]`. Bits [2:0] of both fields have no effect.
- R4: `panel_hsync` is 1 when `pix_x` is at least `panel_start` and below `panel_end`, compared over all 11 bits.
- R5: `line_y` steps by one in the cycle where `pix_x` becomes `{crt_start[10:3],3'b000}`. It goes to 0 instead when it already equals or exceeds the effective vertical total. If that pixel is never reached in a line, `line_y` holds.
- R6: In progressive mode, `vblank` is 1 when `line_y` is between `vblank_start` and `vblank_end`, both inclusive.
- R7: `vsync` is 1 when `line_y` is at least `vsync_start` and below `vsync_end`.
- R8: `pixel_active` is 1 when `pix_x` is at most the horizontal active field and `line_y` is at most the vertical active field.
- R9: With `interlace_en` high, the effective vertical total is the programmed total with bit 0 cleared. `vblank` then covers lines from vertical active + 1 through that effective total, and the vertical blank register has no effect.
- R10: Register map, each as {field in [26:16], field in [10:0]}: address 0 {h_total, h_active}, 1 {crt_end, crt_start}, 2 {panel_end, panel_start}, 3 {v_total, v_active}, 4 {vblank_end, vblank_start}, 5 {vsync_end, vsync_start}. `rd_data` shows the register at `rd_addr` one cycle later, with bits [31:27] and [15:11] at 0. Addresses 6 and 7 read 0 and ignore writes.
- R11: A write presented while `lock` is high leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lock | input | 1 | Blocks register writes while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| interlace_en | input | 1 | Interlaced vertical timing |
| crt_hsync | output | 1 | CRT horizontal sync, 8-pixel resolution |
| panel_hsync | output | 1 | Panel horizontal sync, 1-pixel resolution |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| pixel_active | output | 1 | Visible pixel flag |
| pix_x | output | 11 | Current pixel number |
| line_y | output | 11 | Current line number |

## Verification
The CRT sync start carries nonzero low bits. A design that compared all 11 bits would move the CRT edge off the 8-pixel grid. The same design would also step the line counter on the wrong pixel, so every later line number would be off. A configuration whose CRT start lies beyond the line length checks that the line counter freezes. A design that also stepped the line at the end of each line would keep counting. The interlaced configuration programs an odd vertical total and a misleading blank register, so a design that ignores the mode shows a frame one line too long and a blank window in the wrong place. Writes under lock, all-ones writes and writes to unused addresses are read back, catching a lock that leaks, stray reserved bits and aliased addresses.

// File: rtl/rtg_pkg.sv
// Shared constants and the decoded timing configuration for the raster
// timing generator. Assumes 11-bit timing fields packed twice per 32-bit word.
package rtg_pkg;
    localparam int FW        = 11;            // width of one timing field
    localparam int DW        = 32;            // register word width
    localparam int AW        = 3;             // register address width
    localparam int NREG      = 6;             // implemented registers
    localparam int HI_LSB    = 16;            // lsb of the upper field
    localparam int CHAR_BITS = 3;             // log2 of the CRT character width
    localparam int CW        = FW - CHAR_BITS; // CRT character position width
    localparam int HI_PAD    = DW - HI_LSB - FW;
    localparam int LO_PAD    = HI_LSB - FW;

    localparam int A_HORZ   = 0;
    localparam int A_CRT    = 1;
    localparam int A_PANEL  = 2;
    localparam int A_VERT   = 3;
    localparam int A_VBLANK = 4;
    localparam int A_VSYNC  = 5;

    typedef struct packed {
        logic [FW-1:0] h_total;
        logic [FW-1:0] h_active;
        logic [FW-1:0] crt_start;
        logic [FW-1:0] crt_end;
        logic [FW-1:0] panel_start;
        logic [FW-1:0] panel_end;
        logic [FW-1:0] v_total;
        logic [FW-1:0] v_active;
        logic [FW-1:0] vblank_start;
        logic [FW-1:0] vblank_end;
        logic [FW-1:0] vsync_start;
        logic [FW-1:0] vsync_end;
    } rtg_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
// Timing register file. Holds NREG words of two FW-bit fields each, accepts
// writes only while lock is low, and returns a registered read word with the
// reserved bits at zero. Assumes a single write port and one read port.
module rtg_regs
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output rtg_cfg_t      cfg
);
    logic [NREG-1:0][FW-1:0] lo_q;
    logic [NREG-1:0][FW-1:0] hi_q;
    logic                    wr_ok;

    assign wr_ok = wr_en && !lock;

    // Store both fields of the addressed word on an unlocked write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end else if (wr_ok && (wr_addr == AW'(i))) begin
                lo_q[i] <= wr_data[FW-1:0];
                hi_q[i] <= wr_data[HI_LSB +: FW];
            end
        end
    end

    // Registered read with reserved bits forced low and unused addresses zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (int'(rd_addr) < NREG) begin
            rd_data <= {{HI_PAD{1'b0}}, hi_q[rd_addr], {LO_PAD{1'b0}}, lo_q[rd_addr]};
        end else begin
            rd_data <= '0;
        end
    end

    // Unpack the stored words into named timing fields.
    always_comb begin
        cfg.h_total      = hi_q[A_HORZ];
        cfg.h_active     = lo_q[A_HORZ];
        cfg.crt_end      = hi_q[A_CRT];
        cfg.crt_start    = lo_q[A_CRT];
        cfg.panel_end    = hi_q[A_PANEL];
        cfg.panel_start  = lo_q[A_PANEL];
        cfg.v_total      = hi_q[A_VERT];
        cfg.v_active     = lo_q[A_VERT];
        cfg.vblank_end   = hi_q[A_VBLANK];
        cfg.vblank_start = lo_q[A_VBLANK];
        cfg.vsync_end    = hi_q[A_VSYNC];
        cfg.vsync_start  = lo_q[A_VSYNC];
    end

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable({hi_q, lo_q}));
endmodule

// File: rtl/rtg_hcount.sv
// Horizontal half of the timing generator. Runs the pixel counter, derives the
// CRT sync on character boundaries, the panel sync per pixel, and horizontal
// blank. Outputs are registered from the next count so they line up with it.
// Also emits the line-step strobe and the next horizontal active flag.
module rtg_hcount
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] h_total,
    input  logic [FW-1:0] h_active,
    input  logic [CW-1:0] crt_start_ch,
    input  logic [CW-1:0] crt_end_ch,
    input  logic [FW-1:0] panel_start,
    input  logic [FW-1:0] panel_end,
    output logic [FW-1:0] hcnt_q,
    output logic          line_step,
    output logic          h_act_nxt,
    output logic          crt_hsync,
    output logic          panel_hsync,
    output logic          hblank
);
    logic [FW-1:0] hcnt_nxt;
    logic [CW-1:0] char_nxt;
    logic          crt_nxt;
    logic          panel_nxt;

    // Next pixel position, wrapping once the total is reached or passed.
    always_comb begin
        hcnt_nxt  = (hcnt_q >= h_total) ? '0 : hcnt_q + FW'(1);
        char_nxt  = hcnt_nxt[FW-1:CHAR_BITS];
        crt_nxt   = (char_nxt >= crt_start_ch) && (char_nxt < crt_end_ch);
        panel_nxt = (hcnt_nxt >= panel_start) && (hcnt_nxt < panel_end);
        h_act_nxt = (hcnt_nxt <= h_active);
        line_step = (hcnt_nxt == {crt_start_ch, {CHAR_BITS{1'b0}}});
    end

    // Pixel counter and horizontal outputs, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q      <= '0;
            crt_hsync   <= 1'b0;
            panel_hsync <= 1'b0;
            hblank      <= 1'b0;
        end else begin
            hcnt_q      <= hcnt_nxt;
            crt_hsync   <= crt_nxt;
            panel_hsync <= panel_nxt;
            hblank      <= !h_act_nxt;
        end
    end

    // R2
    pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && hcnt_q != '0) |-> (hcnt_q == $past(hcnt_q) + FW'(1)));

    // R3
    crt_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(crt_hsync) && $past(rst_n, 2)
         && ($past({crt_start_ch, crt_end_ch}) == $past({crt_start_ch, crt_end_ch}, 2)))
        |-> (hcnt_q[CHAR_BITS-1:0] == '0));

    // R4
    panel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(panel_hsync) && $past(rst_n, 2)
         && ($past({panel_start, panel_end}) == $past({panel_start, panel_end}, 2)))
        |-> (hcnt_q == $past(panel_start)));
endmodule

// File: rtl/rtg_vcount.sv
// Vertical half of the timing generator. Steps the line counter on the strobe
// from the horizontal half, applies the interlace rules to the total and blank
// window, and registers vertical sync and blank from the next line number.
module rtg_vcount
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          interlace_en,
    input  logic          line_step,
    input  logic [FW-1:0] v_total,
    input  logic [FW-1:0] v_active,
    input  logic [FW-1:0] vblank_start,
    input  logic [FW-1:0] vblank_end,
    input  logic [FW-1:0] vsync_start,
    input  logic [FW-1:0] vsync_end,
    output logic [FW-1:0] vcnt_q,
    output logic          v_act_nxt,
    output logic          vsync,
    output logic          vblank
);
    logic [FW-1:0] vtot_eff;
    logic [FW-1:0] vb_lo;
    logic [FW-1:0] vb_hi;
    logic [FW-1:0] vcnt_nxt;

    // Interlace forces an odd line count and a blank window with no border.
    always_comb begin
        vtot_eff = interlace_en ? {v_total[FW-1:1], 1'b0} : v_total;
        vb_lo    = interlace_en ? v_active + FW'(1) : vblank_start;
        vb_hi    = interlace_en ? vtot_eff : vblank_end;
    end

    // Next line number: hold between strobes, wrap at the effective total.
    always_comb begin
        if (!line_step) begin
            vcnt_nxt = vcnt_q;
        end else if (vcnt_q >= vtot_eff) begin
            vcnt_nxt = '0;
        end else begin
            vcnt_nxt = vcnt_q + FW'(1);
        end
        v_act_nxt = (vcnt_nxt <= v_active);
    end

    // Line counter and vertical outputs, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt_q <= '0;
            vsync  <= 1'b0;
            vblank <= 1'b0;
        end else begin
            vcnt_q <= vcnt_nxt;
            vsync  <= (vcnt_nxt >= vsync_start) && (vcnt_nxt < vsync_end);
            vblank <= (vcnt_nxt >= vb_lo) && (vcnt_nxt <= vb_hi);
        end
    end

    // R5
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(vcnt_q) && vcnt_q != '0)
        |-> (vcnt_q == $past(vcnt_q) + FW'(1)));
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator. Connects the register file to the
// horizontal and vertical counters and registers the combined pixel-active
// flag. Assumes one pixel per clock and a synchronous active-low reset.
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          interlace_en,
    output logic          crt_hsync,
    output logic          panel_hsync,
    output logic          vsync,
    output logic          hblank,
    output logic          vblank,
    output logic          pixel_active,
    output logic [FW-1:0] pix_x,
    output logic [FW-1:0] line_y
);
    rtg_cfg_t cfg;
    logic     line_step;
    logic     h_act_nxt;
    logic     v_act_nxt;

    rtg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (lock),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    rtg_hcount u_hcount (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_total      (cfg.h_total),
        .h_active     (cfg.h_active),
        .crt_start_ch (cfg.crt_start[FW-1:CHAR_BITS]),
        .crt_end_ch   (cfg.crt_end[FW-1:CHAR_BITS]),
        .panel_start  (cfg.panel_start),
        .panel_end    (cfg.panel_end),
        .hcnt_q       (pix_x),
        .line_step    (line_step),
        .h_act_nxt    (h_act_nxt),
        .crt_hsync    (crt_hsync),
        .panel_hsync  (panel_hsync),
        .hblank       (hblank)
    );

    rtg_vcount u_vcount (
        .clk          (clk),
        .rst_n        (rst_n),
        .interlace_en (interlace_en),
        .line_step    (line_step),
        .v_total      (cfg.v_total),
        .v_active     (cfg.v_active),
        .vblank_start (cfg.vblank_start),
        .vblank_end   (cfg.vblank_end),
        .vsync_start  (cfg.vsync_start),
        .vsync_end    (cfg.vsync_end),
        .vcnt_q       (line_y),
        .v_act_nxt    (v_act_nxt),
        .vsync        (vsync),
        .vblank       (vblank)
    );

    // Visible-pixel flag aligned with the registered counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pixel_active <= 1'b0;
        end else begin
            pixel_active <= h_act_nxt && v_act_nxt;
        end
    end

    // R5
    line_on_crt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(line_y) && $past(rst_n)
         && $past(cfg.crt_start[FW-1:CHAR_BITS] < cfg.crt_end[FW-1:CHAR_BITS])
         && $past(cfg.crt_start[FW-1:CHAR_BITS] != '0))
        |-> $rose(crt_hsync));
endmodule

// File: tb/raster_timing_gen_tb.sv
// Bench: table of timing configurations checked against a pixel-by-pixel
// model, then directed checks for reset, register access, lock and a stalled
// line counter.
module raster_timing_gen_tb;
    localparam int FW = 11;
    localparam int NCFG = 3;
    localparam int NWORD = 6;

    // Per configuration: words for addresses 0..5.
    localparam logic [31:0] TBL [NCFG][NWORD] = '{
        '{32'h0027_001F, 32'h002F_0021, 32'h0025_0022, 32'h000B_0007, 32'h000A_0008, 32'h000A_0009},
        '{32'h002F_0027, 32'h0011_0008, 32'h0003_0000, 32'h0009_0005, 32'h0009_0006, 32'h0008_0007},
        '{32'h0017_000F, 32'h0018_0010, 32'h0014_0011, 32'h000D_0009, 32'h0003_0002, 32'h000C_000B}
    };
    localparam logic TBL_IL [NCFG] = '{1'b0, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        interlace_en = 1'b0;
    logic        crt_hsync, panel_hsync, vsync, hblank, vblank, pixel_active;
    logic [FW-1:0] pix_x, line_y;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    raster_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .lock(lock), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .interlace_en(interlace_en), .crt_hsync(crt_hsync), .panel_hsync(panel_hsync),
        .vsync(vsync), .hblank(hblank), .vblank(vblank), .pixel_active(pixel_active),
        .pix_x(pix_x), .line_y(line_y)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = 3'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    // Compare all timing outputs against the model at (mx, my).
    task automatic cmp(input int c, input int mx, input int my);
        int htot, hact, cs, ce, ps, pe, vtot, vact, bs, be, ss, se;
        bit il;
        htot = int'(TBL[c][0][26:16]); hact = int'(TBL[c][0][10:0]);
        ce = int'(TBL[c][1][26:19]);   cs = int'(TBL[c][1][10:3]);
        pe = int'(TBL[c][2][26:16]);   ps = int'(TBL[c][2][10:0]);
        vtot = int'(TBL[c][3][26:16]); vact = int'(TBL[c][3][10:0]);
        il = TBL_IL[c];
        if (il) vtot = vtot & ~1;
        bs = il ? vact + 1 : int'(TBL[c][4][10:0]);
        be = il ? vtot : int'(TBL[c][4][26:16]);
        ss = int'(TBL[c][5][10:0]);    se = int'(TBL[c][5][26:16]);
        check("R2", "pix_x", int'(pix_x), mx);
        check("R5", "line_y", int'(line_y), my);
        check("R2", "hblank", int'(hblank), int'(mx > hact));
        check("R3", "crt_hsync", int'(crt_hsync), int'((mx / 8) >= cs && (mx / 8) < ce));
        check("R4", "panel_hsync", int'(panel_hsync), int'(mx >= ps && mx < pe));
        check("R7", "vsync", int'(vsync), int'(my >= ss && my < se));
        check(il ? "R9" : "R6", "vblank", int'(vblank), int'(my >= bs && my <= be));
        check("R8", "pixel_active", int'(pixel_active), int'(mx <= hact && my <= vact));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int mx, my, htot, vtot, cs_px, n_cyc, guard;
        int held;

        // R1: reset state of outputs and registers
        repeat (3) @(negedge clk);
        check("R1", "pix_x in reset", int'(pix_x), 0);
        check("R1", "line_y in reset", int'(line_y), 0);
        check("R1", "sync/blank in reset",
              int'({crt_hsync, panel_hsync, vsync, hblank, vblank, pixel_active}), 0);
        rst_n = 1'b1;
        for (int a = 0; a < NWORD; a++) begin
            rd(a, d);
            check("R1", "register cleared", int'(d), 0);
        end

        // R10: reserved bits read zero, unused address ignored
        wr(5, 32'hFFFF_FFFF);
        rd(5, d);
        check("R10", "reserved bits", int'(d), int'(32'h07FF_07FF));
        wr(6, 32'h1234_5678);
        rd(6, d);
        check("R10", "unused address", int'(d), 0);
        wr(3, 32'h0155_02AA);
        rd(3, d);
        check("R10", "field placement", int'(d), int'(32'h0155_02AA));

        // R11: locked write leaves register unchanged
        lock = 1'b1;
        wr(5, 32'h0001_0002);
        rd(5, d);
        check("R11", "locked write", int'(d), int'(32'h07FF_07FF));
        lock = 1'b0;

        // Table walk: program, align to frame start, compare every pixel
        for (int c = 0; c < NCFG; c++) begin
            interlace_en = TBL_IL[c];
            for (int a = 0; a < NWORD; a++) wr(a, TBL[c][a]);
            htot = int'(TBL[c][0][26:16]);
            vtot = int'(TBL[c][3][26:16]);
            if (TBL_IL[c]) vtot = vtot & ~1;
            cs_px = int'(TBL[c][1][10:3]) * 8;
            guard = 0;
            @(negedge clk);
            while (!(pix_x == '0 && line_y == '0) && guard < 20000) begin
                @(negedge clk);
                guard++;
            end
            check("R5", "frame start reached", int'(guard < 20000), 1);
            mx = 0; my = 0;
            cmp(c, mx, my);
            n_cyc = 2 * (htot + 1) * (vtot + 1) + 5;
            for (int k = 0; k < n_cyc; k++) begin
                @(negedge clk);
                mx = (mx >= htot) ? 0 : mx + 1;
                if (mx == cs_px) my = (my >= vtot) ? 0 : my + 1;
                cmp(c, mx, my);
            end
        end

        // R5: CRT start beyond the line length freezes the line counter
        interlace_en = 1'b0;
        wr(1, 32'h0110_0100);
        wr(0, 32'h000F_0008);
        repeat (20) @(negedge clk);
        held = int'(line_y);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            check("R5", "line held without crt start pixel", int'(line_y), held);
        end
        check("R2", "short line wraps", int'(pix_x <= 11'd15), 1);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "pix_x after reset", int'(pix_x), 0);
        check("R1", "line_y after reset", int'(line_y), 0);
        check("R1", "outputs after reset",
              int'({crt_hsync, panel_hsync, vsync, hblank, vblank, pixel_active}), 0);
        check("R1", "rd_data after reset", int'(rd_data), 0);
        rst_n = 1'b1;
        rd(0, d);
        check("R1", "register cleared by reset", int'(d), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule